// File: doc/BRIEF.md
# AHB Burst Protocol Monitor

This block is a passive observer placed beside an AHB-style master. It samples the address and control phase of the bus (address, transfer type, burst type, transfer size) in every cycle where the bus is ready. It raises error flags when a burst is built wrongly. Four areas are checked:

- how a burst opens;
- how its later beats are marked and counted;
- whether every beat is aligned to its transfer size;
- whether any beat leaves the 1 KB address region of the burst's first beat.

It never drives the bus. It does not model slaves, data or responses.

Each error kind has two flags. A one-cycle pulse marks the cycle that offended. A sticky bit stays set until reset. An informational pulse reports a fixed-length burst that was legally cut off by a new burst. A counter reports how many bursts have completed. All results are registered: they appear one clock after the edge that sampled the transfer.

Top module: `ahb_burst_monitor`

## Requirements
- R1: While reset is asserted, and after it is released until a transfer is sampled, `err_pulse`, `err_sticky`, `early_term` and `burst_cnt` are all zero.
- R2: Every sampled NONSEQ (`htrans`=2'b10) or SEQ (2'b11) beat must have the low `hsize` address bits at zero: `hsize`=1 (halfword) needs `haddr[0]`=0 and `hsize`=2 (word) needs `haddr[1:0]`=0. A violation sets `err_pulse[2]` for one cycle.
- R3: A SEQ beat inside a burst whose `haddr[31:10]` differs from that of the burst's NONSEQ beat sets `err_pulse[3]`.
- R4: A SEQ or BUSY (2'b01) transfer sampled while no burst is open sets `err_pulse[0]`. A fixed-length burst closes on its last beat, so an extra SEQ after it also sets this bit.
- R5: For incrementing bursts (`hburst` INCR=001, INCR4=011, INCR8=101, INCR16=111), each SEQ address must equal the previous beat's address plus 2^`hsize`. A mismatch sets `err_pulse[1]`. Wrapping bursts (WRAP4=010, WRAP8=100, WRAP16=110) are exempt from this check.
- R6: An IDLE (2'b00) sampled while a fixed-length burst (4, 8 or 16 beats) still has beats to go sets `err_pulse[4]`.
- R7: A NONSEQ sampled while a fixed-length burst still has beats to go pulses `early_term` for one cycle. This sets no error bit.
- R8: `burst_cnt` rises by one for each of these events: a SINGLE (000) NONSEQ; the final beat of a fixed-length burst; an undefined-length INCR burst ended by a sampled IDLE or NONSEQ. Two of these can fall in one sample, giving a rise of two. Bursts cut short under R6 or R7 are not counted.
- R9: BUSY inside an open burst does not advance the beat count. Cycles with `hready` low are ignored entirely.
- R10: Each `err_sticky` bit is set in the same cycle as its `err_pulse` bit. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| haddr | input | 32 | Transfer address |
| htrans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hburst | input | 3 | Burst type |
| hsize | input | 3 | Transfer size, log2 of bytes |
| hready | input | 1 | Transfer sampled when high |
| err_pulse | output | 5 | One-cycle error flags: [0] start, [1] step, [2] align, [3] boundary, [4] short |
| err_sticky | output | 5 | Accumulated error flags, same bit order |
| early_term | output | 1 | One-cycle pulse for a legal early termination |
| burst_cnt | output | 16 | Completed bursts, wraps at its width |

## Verification
Every flag and the counter update on the rising edge that samples a transfer with `hready` high. Results are therefore due exactly one clock after the transfer is presented. The bench drives each transfer on a falling edge and reads the outputs just after the following rising edge. The pulse it reads therefore belongs to that one transfer and to nothing earlier. A cycle with `hready` low is followed by a read that must show all pulses clear and the counter unchanged. After a reset, the bench waits for the two synchroniser stages before presenting any transfer.

// File: rtl/ahb_mon_pkg.sv
package ahb_mon_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [2:0] BT_SINGLE = 3'b000;
  localparam logic [2:0] BT_INCR   = 3'b001;

  localparam int NUM_ERR  = 5;
  localparam int E_START  = 0;
  localparam int E_STEP   = 1;
  localparam int E_ALIGN  = 2;
  localparam int E_BOUND  = 3;
  localparam int E_SHORT  = 4;

  // Beat count of a fixed-length burst type; 1 for SINGLE and INCR
  function automatic logic [4:0] fixed_len(input logic [2:0] bt);
    case (bt[2:1])
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      2'b11:   return 5'd16;
      default: return 5'd1;
    endcase
  endfunction

endpackage

// File: rtl/ahb_mon_rst_sync.sv
module ahb_mon_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/ahb_mon_beat_check.sv
module ahb_mon_beat_check #(
  parameter int ADDR_W  = 32,
  parameter int BOUND_W = 10,
  localparam int REG_W  = ADDR_W - BOUND_W
) (
  input  logic [ADDR_W-1:0] haddr,
  input  logic [2:0]        hsize,
  input  logic              chk_beat,
  input  logic              chk_seq,
  input  logic              chk_step,
  input  logic [REG_W-1:0]  region,
  input  logic [ADDR_W-1:0] prev_addr,
  output logic              align_err,
  output logic              bound_err,
  output logic              step_err
);
  logic [ADDR_W-1:0] size_bytes;
  logic [ADDR_W-1:0] size_mask;

  always_comb begin
    size_bytes = ADDR_W'(1) << hsize;
    size_mask  = size_bytes - ADDR_W'(1);
    align_err  = chk_beat && (|(haddr & size_mask));
    bound_err  = chk_seq && (haddr[ADDR_W-1:BOUND_W] != region);
    step_err   = chk_step && (haddr != (prev_addr + size_bytes));
  end
endmodule

// File: rtl/ahb_mon_tracker.sv
module ahb_mon_tracker
  import ahb_mon_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BOUND_W = 10,
  localparam int REG_W  = ADDR_W - BOUND_W
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic [2:0]        hburst,
  input  logic              hready,
  output logic              chk_beat,
  output logic              chk_seq,
  output logic              chk_step,
  output logic [REG_W-1:0]  region,
  output logic [ADDR_W-1:0] prev_addr,
  output logic              start_err,
  output logic              short_err,
  output logic              early_now,
  output logic [1:0]        done_inc
);
  logic             active_q, active_d;
  logic             fixed_q, fixed_d;
  logic             wrap_q, wrap_d;
  logic [4:0]       left_q, left_d;
  logic [REG_W-1:0] region_q, region_d;
  logic [ADDR_W-1:0] prev_q, prev_d;
  logic             load_en;

  always_comb begin
    active_d  = active_q;
    fixed_d   = fixed_q;
    wrap_d    = wrap_q;
    left_d    = left_q;
    region_d  = region_q;
    prev_d    = prev_q;
    load_en   = 1'b0;
    start_err = 1'b0;
    short_err = 1'b0;
    early_now = 1'b0;
    done_inc  = 2'd0;
    chk_beat  = hready && htrans[1];
    chk_seq   = hready && (htrans == TR_SEQ) && active_q;
    chk_step  = chk_seq && !wrap_q;
    if (hready) begin
      load_en = 1'b1;
      case (trans_e'(htrans))
        TR_IDLE: begin
          if (active_q) begin
            if (fixed_q) short_err = 1'b1;
            else         done_inc  = 2'd1;
          end
          active_d = 1'b0;
        end
        TR_BUSY: begin
          if (!active_q) start_err = 1'b1;
        end
        TR_NONSEQ: begin
          if (active_q) begin
            if (fixed_q) early_now = 1'b1;
            else         done_inc  = 2'd1;
          end
          region_d = haddr[ADDR_W-1:BOUND_W];
          prev_d   = haddr;
          fixed_d  = (hburst[2:1] != 2'b00);
          wrap_d   = (hburst != BT_SINGLE) && !hburst[0];
          left_d   = fixed_len(hburst) - 5'd1;
          if (hburst == BT_SINGLE) begin
            done_inc = done_inc + 2'd1;
            active_d = 1'b0;
          end else begin
            active_d = 1'b1;
          end
        end
        default: begin
          if (!active_q) begin
            start_err = 1'b1;
          end else begin
            prev_d = haddr;
            if (fixed_q) begin
              left_d = left_q - 5'd1;
              if (left_q == 5'd1) begin
                done_inc = 2'd1;
                active_d = 1'b0;
              end
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      active_q <= 1'b0;
      fixed_q  <= 1'b0;
      wrap_q   <= 1'b0;
      left_q   <= 5'd0;
      region_q <= '0;
      prev_q   <= '0;
    end else if (load_en) begin
      active_q <= active_d;
      fixed_q  <= fixed_d;
      wrap_q   <= wrap_d;
      left_q   <= left_d;
      region_q <= region_d;
      prev_q   <= prev_d;
    end
  end

  assign region    = region_q;
  assign prev_addr = prev_q;

  AST_FIXED_LEFT_BOUNDED: assert property (@(posedge clk) disable iff (!srst_n)
    active_q && fixed_q |-> (left_q != 5'd0) && (left_q < 5'd16)) else $error("left"); // R9
endmodule

// File: rtl/ahb_mon_flags.sv
module ahb_mon_flags #(
  parameter int NUM_ERR = 5,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               srst_n,
  input  logic [NUM_ERR-1:0] err_now,
  input  logic               early_now,
  input  logic [1:0]         done_inc,
  output logic [NUM_ERR-1:0] err_pulse,
  output logic [NUM_ERR-1:0] err_sticky,
  output logic               early_term,
  output logic [CNT_W-1:0]   burst_cnt
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_ERR; gi++) begin : g_flag
      logic pulse_q, sticky_q, sticky_d;
      always_comb sticky_d = sticky_q | err_now[gi];
      always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) begin
          pulse_q  <= 1'b0;
          sticky_q <= 1'b0;
        end else begin
          pulse_q  <= err_now[gi];
          sticky_q <= sticky_d;
        end
      end
      assign err_pulse[gi]  = pulse_q;
      assign err_sticky[gi] = sticky_q;
    end
  endgenerate

  logic             early_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = (done_inc != 2'd0);
    cnt_d  = cnt_q + CNT_W'(done_inc);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      early_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      early_q <= early_now;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign early_term = early_q;
  assign burst_cnt  = cnt_q;

  AST_STICKY_COVERS_PULSE: assert property (@(posedge clk) disable iff (!srst_n)
    (err_pulse & ~err_sticky) == '0) else $error("sticky"); // R10
  AST_STICKY_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!srst_n)
    (err_sticky & $past(err_sticky)) == $past(err_sticky)) else $error("hold"); // R10
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!srst_n)
    (CNT_W'(burst_cnt - $past(burst_cnt)) <= CNT_W'(2))) else $error("cnt"); // R8
endmodule

// File: rtl/ahb_burst_monitor.sv
module ahb_burst_monitor
  import ahb_mon_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BOUND_W = 10,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  haddr,
  input  logic [1:0]         htrans,
  input  logic [2:0]         hburst,
  input  logic [2:0]         hsize,
  input  logic               hready,
  output logic [NUM_ERR-1:0] err_pulse,
  output logic [NUM_ERR-1:0] err_sticky,
  output logic               early_term,
  output logic [CNT_W-1:0]   burst_cnt
);
  localparam int REG_W = ADDR_W - BOUND_W;

  logic              srst_n;
  logic              chk_beat, chk_seq, chk_step;
  logic [REG_W-1:0]  region;
  logic [ADDR_W-1:0] prev_addr;
  logic              start_err, short_err, early_now;
  logic              align_err, bound_err, step_err;
  logic [1:0]        done_inc;
  logic [NUM_ERR-1:0] err_now;

  ahb_mon_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  ahb_mon_tracker #(.ADDR_W(ADDR_W), .BOUND_W(BOUND_W)) u_trk (
    .clk(clk), .srst_n(srst_n), .haddr(haddr), .htrans(htrans),
    .hburst(hburst), .hready(hready), .chk_beat(chk_beat),
    .chk_seq(chk_seq), .chk_step(chk_step), .region(region),
    .prev_addr(prev_addr), .start_err(start_err), .short_err(short_err),
    .early_now(early_now), .done_inc(done_inc)
  );

  ahb_mon_beat_check #(.ADDR_W(ADDR_W), .BOUND_W(BOUND_W)) u_chk (
    .haddr(haddr), .hsize(hsize), .chk_beat(chk_beat), .chk_seq(chk_seq),
    .chk_step(chk_step), .region(region), .prev_addr(prev_addr),
    .align_err(align_err), .bound_err(bound_err), .step_err(step_err)
  );

  always_comb begin
    err_now          = '0;
    err_now[E_START] = start_err;
    err_now[E_STEP]  = step_err;
    err_now[E_ALIGN] = align_err;
    err_now[E_BOUND] = bound_err;
    err_now[E_SHORT] = short_err;
  end

  ahb_mon_flags #(.NUM_ERR(NUM_ERR), .CNT_W(CNT_W)) u_flg (
    .clk(clk), .srst_n(srst_n), .err_now(err_now), .early_now(early_now),
    .done_inc(done_inc), .err_pulse(err_pulse), .err_sticky(err_sticky),
    .early_term(early_term), .burst_cnt(burst_cnt)
  );

  AST_PULSE_NEEDS_READY: assert property (@(posedge clk) disable iff (!srst_n)
    ((|err_pulse) || early_term) |-> $past(hready)) else $error("ready"); // R9
  AST_WORD_MISALIGN_FLAGGED: assert property (@(posedge clk) disable iff (!srst_n)
    hready && htrans[1] && (hsize == 3'd2) && (haddr[1:0] != 2'b00) |=> err_pulse[E_ALIGN])
    else $error("align"); // R2
  AST_EARLY_NOT_ERROR: assert property (@(posedge clk) disable iff (!srst_n)
    early_term |-> !err_pulse[E_SHORT]) else $error("early"); // R7
endmodule

// File: tb/ahb_burst_monitor_bench.sv
module ahb_burst_monitor_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic [2:0]  hburst, hsize;
  logic        hready;
  logic [4:0]  err_pulse, err_sticky;
  logic        early_term;
  logic [15:0] burst_cnt;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;

  localparam logic [1:0] IDLE = 2'b00, BUSY = 2'b01, NS = 2'b10, SQ = 2'b11;
  localparam logic [2:0] SGL = 3'b000, INC = 3'b001, WR4 = 3'b010, IN4 = 3'b011, IN8 = 3'b101;
  localparam logic [2:0] HW = 3'd1, WD = 3'd2;

  always #(CLK_PERIOD/2) clk = ~clk;

  ahb_burst_monitor u_ahb_burst_monitor (
    .clk(clk), .rst_n(rst_n), .haddr(haddr), .htrans(htrans), .hburst(hburst),
    .hsize(hsize), .hready(hready), .err_pulse(err_pulse), .err_sticky(err_sticky),
    .early_term(early_term), .burst_cnt(burst_cnt)
  );

  task automatic drive(input logic [1:0] t, input logic [2:0] b, input logic [2:0] s,
                       input logic [31:0] a, input logic rdy);
    @(negedge clk);
    htrans = t; hburst = b; hsize = s; haddr = a; hready = rdy;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic [4:0] ep, input logic ei);
    checks++;
    if (err_pulse !== ep || early_term !== ei || burst_cnt !== 16'(exp_cnt)) begin
      errors++;
      $display("FAIL %s: pulse=%b early=%b cnt=%0d expected pulse=%b early=%b cnt=%0d",
               tag, err_pulse, early_term, burst_cnt, ep, ei, exp_cnt);
    end
  endtask

  task automatic beat(input string tag, input logic [1:0] t, input logic [2:0] b,
                      input logic [2:0] s, input logic [31:0] a,
                      input logic [4:0] ep, input logic ei, input int inc);
    drive(t, b, s, a, 1'b1);
    exp_cnt += inc;
    expect_out(tag, ep, ei);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; htrans = IDLE; hburst = SGL; hsize = WD; haddr = '0; hready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_cnt = 0;
  endtask

  task automatic t_reset();
    do_reset();
    checks++;
    if (err_pulse !== 0 || err_sticky !== 0 || early_term !== 0 || burst_cnt !== 0) begin
      errors++;
      $display("FAIL R1: pulse=%b sticky=%b early=%b cnt=%0d expected all zero",
               err_pulse, err_sticky, early_term, burst_cnt);
    end
  endtask

  task automatic t_good_incr4();
    beat("R8 incr4 b0", NS, IN4, WD, 32'h100, 5'b0, 0, 0);
    beat("R8 incr4 b1", SQ, IN4, WD, 32'h104, 5'b0, 0, 0);
    beat("R8 incr4 b2", SQ, IN4, WD, 32'h108, 5'b0, 0, 0);
    beat("R8 incr4 last", SQ, IN4, WD, 32'h10C, 5'b0, 0, 1);
    beat("R8 idle after", IDLE, SGL, WD, 32'h0, 5'b0, 0, 0);
    beat("R8 single", NS, SGL, WD, 32'h40, 5'b0, 0, 1);
  endtask

  task automatic t_align();
    beat("R2 word misalign", NS, SGL, WD, 32'h102, 5'b00100, 0, 1);
    beat("R2 half misalign", NS, SGL, HW, 32'h201, 5'b00100, 0, 1);
    beat("R2 half aligned", NS, SGL, HW, 32'h202, 5'b0, 0, 1);
    beat("R2 seq misalign b0", NS, INC, WD, 32'h300, 5'b0, 0, 0);
    beat("R2 seq misalign b1", SQ, INC, HW, 32'h305, 5'b00110, 0, 0);
    beat("R2 incr end", IDLE, SGL, WD, 32'h0, 5'b0, 0, 1);
  endtask

  task automatic t_boundary();
    beat("R3 b0", NS, IN4, WD, 32'h3F8, 5'b0, 0, 0);
    beat("R3 b1", SQ, IN4, WD, 32'h3FC, 5'b0, 0, 0);
    beat("R3 cross", SQ, IN4, WD, 32'h400, 5'b01000, 0, 0);
    beat("R3 cross last", SQ, IN4, WD, 32'h404, 5'b01000, 0, 1);
  endtask

  task automatic t_start();
    beat("R4 seq no burst", SQ, INC, WD, 32'h10, 5'b00001, 0, 0);
    beat("R4 busy no burst", BUSY, INC, WD, 32'h10, 5'b00001, 0, 0);
  endtask

  task automatic t_step_wrap();
    beat("R5 b0", NS, IN4, WD, 32'h500, 5'b0, 0, 0);
    beat("R5 skipped addr", SQ, IN4, WD, 32'h508, 5'b00010, 0, 0);
    beat("R6 idle cut", IDLE, SGL, WD, 32'h0, 5'b10000, 0, 0);
    beat("R5 wrap b0", NS, WR4, WD, 32'h508, 5'b0, 0, 0);
    beat("R5 wrap b1", SQ, WR4, WD, 32'h50C, 5'b0, 0, 0);
    beat("R5 wrap b2", SQ, WR4, WD, 32'h500, 5'b0, 0, 0);
    beat("R5 wrap last", SQ, WR4, WD, 32'h504, 5'b0, 0, 1);
  endtask

  task automatic t_short_early();
    beat("R6 b0", NS, IN8, WD, 32'h600, 5'b0, 0, 0);
    beat("R6 b1", SQ, IN8, WD, 32'h604, 5'b0, 0, 0);
    beat("R6 idle short", IDLE, SGL, WD, 32'h0, 5'b10000, 0, 0);
    beat("R7 b0", NS, IN4, WD, 32'h700, 5'b0, 0, 0);
    beat("R7 b1", SQ, IN4, WD, 32'h704, 5'b0, 0, 0);
    beat("R7 new nonseq", NS, SGL, WD, 32'h800, 5'b0, 1, 1);
  endtask

  task automatic t_busy_ready();
    beat("R9 b0", NS, IN4, WD, 32'h900, 5'b0, 0, 0);
    beat("R9 busy", BUSY, IN4, WD, 32'h904, 5'b0, 0, 0);
    drive(SQ, IN4, WD, 32'h123, 1'b0);
    expect_out("R9 hready low ignored", 5'b0, 0);
    beat("R9 b1", SQ, IN4, WD, 32'h904, 5'b0, 0, 0);
    beat("R9 b2", SQ, IN4, WD, 32'h908, 5'b0, 0, 0);
    beat("R9 last", SQ, IN4, WD, 32'h90C, 5'b0, 0, 1);
    beat("R9 extra seq", SQ, IN4, WD, 32'h910, 5'b00001, 0, 0);
  endtask

  task automatic t_undef_incr();
    beat("R8 incr b0", NS, INC, WD, 32'hA00, 5'b0, 0, 0);
    beat("R8 incr b1", SQ, INC, WD, 32'hA04, 5'b0, 0, 0);
    beat("R8 incr b2", SQ, INC, WD, 32'hA08, 5'b0, 0, 0);
    beat("R8 incr idle end", IDLE, SGL, WD, 32'h0, 5'b0, 0, 1);
    beat("R8 incr2 b0", NS, INC, WD, 32'hB00, 5'b0, 0, 0);
    beat("R8 incr2 b1", SQ, INC, WD, 32'hB04, 5'b0, 0, 0);
    beat("R8 incr end by single", NS, SGL, WD, 32'hC00, 5'b0, 0, 2);
  endtask

  task automatic t_sticky();
    beat("R10 quiet", IDLE, SGL, WD, 32'h0, 5'b0, 0, 0);
    checks++;
    if (err_sticky !== 5'h1F) begin
      errors++;
      $display("FAIL R10: sticky=%b expected %b", err_sticky, 5'h1F);
    end
    do_reset();
    checks++;
    if (err_sticky !== 5'h0 || burst_cnt !== 16'd0) begin
      errors++;
      $display("FAIL R10: after reset sticky=%b cnt=%0d expected 0 0", err_sticky, burst_cnt);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_good_incr4();
    t_align();
    t_boundary();
    t_start();
    t_step_wrap();
    t_short_early();
    t_busy_ready();
    t_undef_incr();
    t_sticky();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule